// File: doc/BRIEF.md
# Multi-Mode Shift and Funnel Unit

This block is the shift datapath of a 64-bit integer execution stage. One shared datapath covers logical left shifts, logical right shifts and arithmetic right shifts at several operand widths. A logical left shift is issued as a left funnel with the value in `src0_i` and zero in `src1_i`. A logical right shift is issued as a right funnel with zero in `src0_i` and the value in `src1_i`. An arithmetic right shift uses one of the sign-extending modes or the signed 64-bit mode.

The shift amount is the immediate when the immediate-valid flag is set. Otherwise it comes from the low bits of the third operand, `src2_i`. The result is always a full 64-bit word. The arithmetic right modes also produce the two carry flags, `ca_o` and `ca32_o`.

The shift logic is combinational and feeds one output register stage. Each result therefore appears one clock after its operands are presented.

Top module: `shfunnel_unit`

## Requirements
- R1: The outputs are registered. A set of inputs presented before a rising edge shows on `result_o`, `ca_o` and `ca32_o` after that edge, and not before it. While `rst_n` is low, all outputs are 0.
- R2: When `imm_vld_i` is 1, the effective amount is `imm_amt_i`. When `imm_vld_i` is 0, the effective amount is `src2_i[6:0]`. When the immediate is used, `src2_i` has no effect on the result.
- R3: The mode encoding is 0 = funnel 8, 1 = funnel 16, 2 = funnel 32, 3 = funnel 64. With `right_i` = 0, a funnel mode of width W returns the upper W bits of `{src0_i[W-1:0], src1_i[W-1:0]}` shifted left by the amount.
- R4: With `right_i` = 1, a funnel mode of width W returns the lower W bits of `{src0_i[W-1:0], src1_i[W-1:0]}` shifted right by the amount.
- R5: In the funnel modes, the amount is taken modulo W. The W-bit result is zero-extended to 64 bits.
- R6: The mode encoding is 4 = sign-extend from 8, 5 = sign-extend from 16, 6 = sign-extend from 32, 7 = signed 64. These modes first sign-extend `src0_i` from the selected width to 64 bits. They then shift arithmetically right when `right_i` = 1, or logically left when `right_i` = 0.
- R7: In modes 4 to 7, the amount is the full 7-bit value. Any amount of 64 or more gives 64 copies of the sign bit for a right shift, and zero for a left shift.
- R8: In modes 4 to 7 with `right_i` = 1, `ca_o` is 1 exactly when the extended value is negative and at least one 1 bit is shifted out. An amount of 0 gives `ca_o` = 0.
- R9: `ca32_o` always equals `ca_o`. Both carry flags are 0 in the funnel modes and for left shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Shift mode (encoding given in R3 and R6) |
| right_i | input | 1 | 1 = shift right, 0 = shift left |
| imm_vld_i | input | 1 | Use the immediate amount instead of `src2_i` |
| imm_amt_i | input | 7 | Immediate shift amount |
| src0_i | input | 64 | Upper funnel operand, or the value for the sign-extend and signed modes |
| src1_i | input | 64 | Lower funnel operand |
| src2_i | input | 64 | Register shift amount (low 7 bits used) |
| result_o | output | 64 | Registered 64-bit result |
| ca_o | output | 1 | Registered carry flag |
| ca32_o | output | 1 | Registered 32-bit carry flag |

## Verification
Every result and both carry flags are due exactly one rising edge after their operands are applied. The bench drives operands on the falling edge and reads the outputs on the next falling edge, half a period after the register has loaded. One directed check reads just before that rising edge to confirm the previous result is still held there. The clocked properties use `|=>` for the same reason, relating the inputs of one cycle to the outputs of the next.

// File: rtl/shfunnel_pkg.sv
package shfunnel_pkg;

   typedef enum logic [2:0] {
      SHF_FUN8  = 3'd0,
      SHF_FUN16 = 3'd1,
      SHF_FUN32 = 3'd2,
      SHF_FUN64 = 3'd3,
      SHF_SX8   = 3'd4,
      SHF_SX16  = 3'd5,
      SHF_SX32  = 3'd6,
      SHF_S64   = 3'd7
   } shf_mode_e;

   // width of funnel lane idx when the widest lane equals xlen
   function automatic int unsigned lane_width(int unsigned xlen, int unsigned idx,
                                              int unsigned lanes);
      return xlen >> (lanes - 1 - idx);
   endfunction

endpackage

// File: rtl/shfunnel_amt_sel.sv
module shfunnel_amt_sel #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned AMT_W = 7
) (
   input  logic             imm_vld_i,
   input  logic [AMT_W-1:0] imm_amt_i,
   input  logic [XLEN-1:0]  reg_amt_i,
   output logic [AMT_W-1:0] amt_o
);
   // R2: immediate wins when flagged, else low bits of the register operand
   always_comb begin
      if (imm_vld_i) amt_o = imm_amt_i;
      else           amt_o = reg_amt_i[AMT_W-1:0];
   end
endmodule

// File: rtl/shfunnel_lane.sv
module shfunnel_lane #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned W     = 8,
   parameter int unsigned AMT_W = 7
) (
   input  logic [XLEN-1:0]  hi_i,
   input  logic [XLEN-1:0]  lo_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             right_i,
   output logic [XLEN-1:0]  res_o
);
   localparam int unsigned SW = $clog2(W);

   logic [2*W-1:0] cat;
   logic [2*W-1:0] cat_l;
   logic [2*W-1:0] cat_r;
   logic [SW-1:0]  sh;

   assign cat   = {hi_i[W-1:0], lo_i[W-1:0]};
   assign sh    = amt_i[SW-1:0];           // modulo W (R5)
   assign cat_l = cat << sh;
   assign cat_r = cat >> sh;

   always_comb begin
      res_o = '0;                           // zero-extend (R5)
      if (right_i) res_o[W-1:0] = cat_r[W-1:0];
      else         res_o[W-1:0] = cat_l[2*W-1:W];
   end
endmodule

// File: rtl/shfunnel_arith.sv
module shfunnel_arith
   import shfunnel_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned AMT_W = 7
) (
   input  logic [2:0]       mode_i,
   input  logic             right_i,
   input  logic [XLEN-1:0]  src_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [XLEN-1:0]  res_o,
   output logic             ca_o
);
   localparam int unsigned SHW = $clog2(XLEN);

   logic [XLEN-1:0] ext;
   logic [XLEN-1:0] sra;
   logic [XLEN-1:0] sll;
   logic [XLEN-1:0] lost_mask;
   logic [SHW-1:0]  sh;
   logic            sgn;
   logic            big;

   always_comb begin
      unique case (shf_mode_e'(mode_i))
         SHF_SX8:  ext = {{(XLEN-8){src_i[7]}},   src_i[7:0]};
         SHF_SX16: ext = {{(XLEN-16){src_i[15]}}, src_i[15:0]};
         SHF_SX32: ext = {{(XLEN-32){src_i[31]}}, src_i[31:0]};
         default:  ext = src_i;
      endcase
   end

   assign sgn       = ext[XLEN-1];
   assign big       = (amt_i >= AMT_W'(XLEN));
   assign sh        = amt_i[SHW-1:0];
   assign sra       = XLEN'($signed(ext) >>> sh);
   assign sll       = ext << sh;
   assign lost_mask = big ? '1 : ((XLEN'(1) << sh) - XLEN'(1));

   always_comb begin
      if (right_i) res_o = big ? {XLEN{sgn}} : sra;
      else         res_o = big ? '0 : sll;
      ca_o = right_i & sgn & (|(ext & lost_mask));
   end
endmodule

// File: rtl/shfunnel_unit.sv
module shfunnel_unit
   import shfunnel_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned AMT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_i,
   input  logic             right_i,
   input  logic             imm_vld_i,
   input  logic [AMT_W-1:0] imm_amt_i,
   input  logic [XLEN-1:0]  src0_i,
   input  logic [XLEN-1:0]  src1_i,
   input  logic [XLEN-1:0]  src2_i,
   output logic [XLEN-1:0]  result_o,
   output logic             ca_o,
   output logic             ca32_o
);
   localparam int unsigned LANES = 4;

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("shfunnel_unit: XLEN must be 64");
      end
      if (AMT_W != $clog2(XLEN) + 1) begin : g_bad_amt
         $error("shfunnel_unit: AMT_W must be clog2(XLEN)+1");
      end
   endgenerate

   logic [AMT_W-1:0] amt;
   logic [XLEN-1:0]  lane_res [LANES];
   logic [XLEN-1:0]  fun_res;
   logic [XLEN-1:0]  ari_res;
   logic             ari_ca;
   logic             is_arith;

   shfunnel_amt_sel #(.XLEN(XLEN), .AMT_W(AMT_W)) u_amt (
      .imm_vld_i (imm_vld_i),
      .imm_amt_i (imm_amt_i),
      .reg_amt_i (src2_i),
      .amt_o     (amt)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      shfunnel_lane #(
         .XLEN  (XLEN),
         .W     (lane_width(XLEN, i, LANES)),
         .AMT_W (AMT_W)
      ) u_lane (
         .hi_i    (src0_i),
         .lo_i    (src1_i),
         .amt_i   (amt),
         .right_i (right_i),
         .res_o   (lane_res[i])
      );
   end

   shfunnel_arith #(.XLEN(XLEN), .AMT_W(AMT_W)) u_arith (
      .mode_i  (mode_i),
      .right_i (right_i),
      .src_i   (src0_i),
      .amt_i   (amt),
      .res_o   (ari_res),
      .ca_o    (ari_ca)
   );

   assign is_arith = mode_i[2];
   assign fun_res  = lane_res[mode_i[1:0]];

   // R1: single output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         ca_o     <= 1'b0;
         ca32_o   <= 1'b0;
      end else begin
         result_o <= is_arith ? ari_res : fun_res;
         ca_o     <= is_arith & ari_ca;
         ca32_o   <= is_arith & ari_ca;
      end
   end
endmodule

// File: rtl/shfunnel_unit_chk.sv
module shfunnel_unit_chk #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned AMT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode_i,
   input logic             right_i,
   input logic             imm_vld_i,
   input logic [AMT_W-1:0] imm_amt_i,
   input logic [XLEN-1:0]  src0_i,
   input logic [XLEN-1:0]  src2_i,
   input logic [XLEN-1:0]  result_o,
   input logic             ca_o,
   input logic             ca32_o
);
   a_r9_funnel_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[2]) |=> (!ca_o && !ca32_o));

   a_r9_left_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (!right_i) |=> (!ca_o && !ca32_o));

   a_r8_zero_amt_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_vld_i && imm_amt_i == '0) |=> !ca_o);

   a_r8_positive_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd7 && !src0_i[XLEN-1]) |=> !ca_o);

   a_r5_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[2] == 1'b0 && mode_i[1:0] != 2'd3)
         |=> ((result_o >> (32'd8 << $past(mode_i[1:0]))) == '0));

   a_r7_big_amount_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd7 && right_i && !imm_vld_i && src2_i[6] && src0_i[XLEN-1])
         |=> (&result_o && ca_o));

   a_r9_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
      ca_o == ca32_o);
endmodule

bind shfunnel_unit shfunnel_unit_chk #(.XLEN(XLEN), .AMT_W(AMT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .right_i   (right_i),
   .imm_vld_i (imm_vld_i),
   .imm_amt_i (imm_amt_i),
   .src0_i    (src0_i),
   .src2_i    (src2_i),
   .result_o  (result_o),
   .ca_o      (ca_o),
   .ca32_o    (ca32_o)
);

// File: tb/shfunnel_unit_tb.sv
`timescale 1ns/1ps
module shfunnel_unit_tb;

   typedef struct packed {
      logic [2:0]  mode;
      logic        right;
      logic        iv;
      logic [6:0]  imm;
      logic [63:0] s0;
      logic [63:0] s1;
      logic [63:0] s2;
      logic [63:0] exp_res;
      logic        exp_ca;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   // requirement number in the last field: R2..R9
   localparam vec_t VECS [NV] = '{
      '{3'd3, 1'b0, 1'b0, 7'd0,  64'h1, 64'h0, 64'd4, 64'h10, 1'b0, 8'd3},                        // R3
      '{3'd3, 1'b1, 1'b0, 7'd0,  64'h0, 64'h100, 64'd4, 64'h10, 1'b0, 8'd4},                      // R4
      '{3'd2, 1'b0, 1'b0, 7'd0,  64'h8000_0001, 64'h0, 64'd1, 64'h2, 1'b0, 8'd3},                 // R3
      '{3'd0, 1'b1, 1'b0, 7'd0,  64'hAB, 64'hCD, 64'd4, 64'hBC, 1'b0, 8'd4},                      // R4
      '{3'd1, 1'b0, 1'b0, 7'd0,  64'h8001, 64'h8000, 64'd17, 64'h3, 1'b0, 8'd5},                  // R5
      '{3'd6, 1'b1, 1'b1, 7'd0,  64'h8000_0000, 64'h0, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd6},// R6
      '{3'd6, 1'b1, 1'b1, 7'd31, 64'h8000_0001, 64'h0, 64'h0, ONES, 1'b1, 8'd8},                  // R8
      '{3'd6, 1'b1, 1'b1, 7'd16, 64'h8000_0000, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_8000, 1'b0, 8'd6},// R6
      '{3'd7, 1'b1, 1'b1, 7'd63, 64'h8000_0000_0000_0000, 64'h0, 64'h0, ONES, 1'b0, 8'd8},        // R8
      '{3'd7, 1'b1, 1'b1, 7'd32, 64'h7000_0000_0000_0001, 64'h0, 64'h0, 64'h7000_0000, 1'b0, 8'd6},// R6
      '{3'd7, 1'b1, 1'b0, 7'd0,  64'h8000_0000_0000_0000, 64'h0, 64'd64, ONES, 1'b1, 8'd7},       // R7
      '{3'd7, 1'b1, 1'b0, 7'd0,  64'h8000_0000_0000_0001, 64'h0, 64'h80,
                                 64'h8000_0000_0000_0001, 1'b0, 8'd7},                             // R7
      '{3'd4, 1'b1, 1'b0, 7'd0,  64'h81, 64'h0, 64'd1, 64'hFFFF_FFFF_FFFF_FFC0, 1'b1, 8'd8},      // R8
      '{3'd5, 1'b0, 1'b0, 7'd0,  64'h8001, 64'h0, 64'd4, 64'hFFFF_FFFF_FFF8_0010, 1'b0, 8'd9},    // R9
      '{3'd7, 1'b1, 1'b1, 7'd5,  64'hFFFF_FFFF_FFFF_FFC0, 64'h0, 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'd2}, // R2
      '{3'd3, 1'b1, 1'b0, 7'd0,  64'h1234, 64'h5678, 64'd0, 64'h5678, 1'b0, 8'd4},                // R4
      '{3'd2, 1'b1, 1'b0, 7'd0,  64'h1, 64'h0, 64'd4, 64'h1000_0000, 1'b0, 8'd4},                 // R4
      '{3'd3, 1'b0, 1'b0, 7'd0,  64'h8000_0000_0000_0000, 64'hF000_0000_0000_0000, 64'd68, 64'hF, 1'b0, 8'd5} // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = '0;
   logic        right_i = 1'b0;
   logic        imm_vld_i = 1'b0;
   logic [6:0]  imm_amt_i = '0;
   logic [63:0] src0_i = '0;
   logic [63:0] src1_i = '0;
   logic [63:0] src2_i = '0;
   logic [63:0] result_o;
   logic        ca_o;
   logic        ca32_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shfunnel_unit u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .right_i(right_i),
      .imm_vld_i(imm_vld_i), .imm_amt_i(imm_amt_i), .src0_i(src0_i),
      .src1_i(src1_i), .src2_i(src2_i), .result_o(result_o),
      .ca_o(ca_o), .ca32_o(ca32_o)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // independent bit-level reference model
   task automatic ref_calc(input logic [2:0] m, input logic r, input logic iv,
                           input logic [6:0] im, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] c, output logic [63:0] res, output logic ca);
      int amt;
      amt = iv ? int'(im) : int'(c[6:0]);
      res = '0;
      ca  = 1'b0;
      if (!m[2]) begin
         int w;
         int s;
         logic [127:0] cat;
         w = 8 << m[1:0];
         s = amt % w;
         cat = '0;
         for (int k = 0; k < w; k++) begin
            cat[k]     = b[k];
            cat[w + k] = a[k];
         end
         for (int i = 0; i < w; i++)
            res[i] = r ? cat[i + s] : cat[w + i - s];
      end else begin
         int n;
         logic [63:0] v;
         n = (m == 3'd7) ? 64 : (8 << m[1:0]);
         for (int i = 0; i < 64; i++) v[i] = (i < n) ? a[i] : a[n-1];
         for (int i = 0; i < 64; i++) begin
            if (r) res[i] = (i + amt < 64) ? v[i + amt] : v[63];
            else   res[i] = (i - amt >= 0) ? v[i - amt] : 1'b0;
         end
         if (r && v[63])
            for (int k = 0; k < 64; k++)
               if (k < amt && v[k]) ca = 1'b1;
      end
   endtask

   task automatic drive(input logic [2:0] m, input logic r, input logic iv,
                        input logic [6:0] im, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c);
      mode_i = m; right_i = r; imm_vld_i = iv; imm_amt_i = im;
      src0_i = a; src1_i = b; src2_i = c;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] er;
      logic        ec;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset result", result_o, 64'h0);
      check("R1 reset ca", {63'h0, ca_o}, 64'h0);
      check("R1 reset ca32", {63'h0, ca32_o}, 64'h0);
      // R1: inputs during reset do not reach the outputs
      drive(3'd3, 1'b0, 1'b0, 7'd0, 64'h1, 64'h0, 64'd1);
      @(negedge clk);
      check("R1 held in reset", result_o, 64'h0);
      rst_n = 1'b1;

      // table walk (R2..R9)
      for (int v = 0; v < NV; v++) begin
         drive(VECS[v].mode, VECS[v].right, VECS[v].iv, VECS[v].imm,
               VECS[v].s0, VECS[v].s1, VECS[v].s2);
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d vec%0d result", VECS[v].req, v), result_o, VECS[v].exp_res);
         check($sformatf("R%0d vec%0d ca", VECS[v].req, v), {63'h0, ca_o}, {63'h0, VECS[v].exp_ca});
         check($sformatf("R9 vec%0d ca32", v), {63'h0, ca32_o}, {63'h0, VECS[v].exp_ca});
      end

      // R1: latency of exactly one edge
      drive(3'd3, 1'b0, 1'b0, 7'd0, 64'h1, 64'h0, 64'd0);
      @(posedge clk);
      @(negedge clk);
      drive(3'd3, 1'b0, 1'b0, 7'd0, 64'h1, 64'h0, 64'd8);
      #1.5;
      check("R1 old value before edge", result_o, 64'h1);
      @(posedge clk);
      @(negedge clk);
      check("R1 new value after edge", result_o, 64'h100);

      // R2: src2 ignored when immediate valid
      drive(3'd6, 1'b1, 1'b1, 7'd4, 64'h8000_00F0, 64'h0, 64'd9);
      @(posedge clk);
      @(negedge clk);
      check("R2 imm priority", result_o, 64'hFFFF_FFFF_F800_000F);

      // random sweep against the reference model, corner amounts included
      for (int t = 0; t < 800; t++) begin
         logic [2:0]  m;
         logic        r;
         logic        iv;
         logic [63:0] a;
         logic [63:0] b;
         logic [63:0] c;
         int          w;
         int          pick;
         int          am;
         m  = 3'($urandom_range(0, 7));
         r  = 1'($urandom);
         iv = 1'($urandom);
         a  = {$urandom, $urandom};
         b  = {$urandom, $urandom};
         c  = {$urandom, $urandom};
         w  = (m == 3'd7 || m == 3'd3) ? 64 : (8 << m[1:0]);
         pick = $urandom_range(0, 4);
         case (pick)
            0: am = 0;
            1: am = w - 1;
            2: am = w;
            3: am = 63;
            default: am = $urandom_range(0, 127);
         endcase
         c[6:0] = 7'(am);
         drive(m, r, iv, 7'(am), a, b, c);
         ref_calc(m, r, iv, 7'(am), a, b, c, er, ec);
         @(posedge clk);
         @(negedge clk);
         check(m[2] ? "R6 R7 random result" : "R3 R4 R5 random result", result_o, er);
         check("R8 random ca", {63'h0, ca_o}, {63'h0, ec});
         check("R9 random ca32", {63'h0, ca32_o}, {63'h0, ec});
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule